// File: doc/BRIEF.md
# Serial Receive Channel Control

This block is the receive side of one asynchronous serial channel. It watches an RX line sampled at sixteen times the bit rate, finds and validates start bits, and shifts in eight data bits least significant first. It then checks the stop bit and places each finished character in a three-entry circular store. Each entry holds the data byte and two status bits. A host side sees a ready flag, the byte and status at the head of the store, and a read strobe that steps to the next entry.

Three single-cycle commands govern the receiver. Enable starts it. Disable stops it at once: a half-built character is lost, but the store keeps everything already received. Reset also stops it, clears the ready and overrun indications, moves the read position onto the write position and clears the status of the entry found there. The stored bytes themselves are never wiped. As a result, reads beyond the unread data return old characters, and this continues until the next reset realigns the pointers.

Top module: `serial_rx_ctl`

## Requirements
- R1: With `os_tick` high, each bit lasts 16 samples. A frame is one low start bit, 8 data bits sent least significant bit first, and one stop bit. A complete frame puts the byte into the store, and `rx_ready` then goes high.
- R2: A start bit is accepted only if the line is still low 8 samples after the falling edge. A low pulse shorter than that returns the receiver to idle, and no character is stored.
- R3: Status bit `rd_frm_err` is 1 when the stop bit was sampled low. Status bit `rd_brk` is 1 when the stop bit was low and all 8 data bits were 0.
- R4: The store holds 3 entries and gives them out in arrival order. `rx_ready` is high exactly while the count of unread entries is nonzero.
- R5: If a character completes while 3 entries are unread, it is dropped, the stored entries are left unchanged, and `overrun` goes high. `overrun` stays high until a reset command.
- R6: A disable command turns `rx_on` low on the next cycle. Any partly assembled character is discarded.
- R7: While `rx_on` is low, stored entries stay readable with their status, and frames on the line are not stored.
- R8: After re-enabling, assembly begins at the next falling edge of the line, not partway through an earlier frame.
- R9: A reset command clears `rx_ready`, `overrun` and `rx_on`. It moves the read pointer to the write pointer and zeroes the status of the entry at that position. It leaves the stored data bytes in place.
- R10: Every read strobe advances the read pointer, even when no entry is unread. A read past the unread data shows the next older stored byte.
- R11: Commands have a fixed priority: reset wins over disable, and disable wins over enable. An enable command with no other command turns `rx_on` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Sample strobe at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| cmd_en | input | 1 | Enable command pulse |
| cmd_dis | input | 1 | Disable command pulse |
| cmd_rst | input | 1 | Receiver reset command pulse |
| rd_stb | input | 1 | Read strobe; advances the read pointer |
| rx_ready | output | 1 | Unread data present |
| rd_data | output | 8 | Data byte at the read pointer |
| rd_frm_err | output | 1 | Framing error status of the head entry |
| rd_brk | output | 1 | Break status of the head entry |
| overrun | output | 1 | Sticky character-dropped flag |
| rx_on | output | 1 | Receiver enabled state |

## Verification
The bench keeps the default eight data bits, 16 samples per bit and three entries, and holds `os_tick` high so that each clock is one sample. This keeps every frame at 160 cycles. The three-entry depth makes it cheap to fill the store, overflow it and wrap the pointers within a few frames. That brings within reach the stale read after a wrap, the status clear at a head that has wrapped, and overrun.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [1:0] {
        ASM_IDLE  = 2'd0,
        ASM_START = 2'd1,
        ASM_DATA  = 2'd2,
        ASM_STOP  = 2'd3
    } asm_state_e;

    localparam int STAT_W = 2;
    localparam int STAT_FE  = 0;
    localparam int STAT_BRK = 1;
endpackage

// File: rtl/srx_assembler.sv
module srx_assembler
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              en,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              done_fe
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int HALF  = OSR / 2;

    typedef struct packed {
        asm_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] shreg;
        logic              prev;
    } asm_t;

    asm_t q, d;

    always_comb begin
        d         = q;
        done      = 1'b0;
        done_data = q.shreg;
        done_fe   = ~rx_s;
        if (tick) begin
            d.prev = rx_s;
            if (!en) begin
                d.state = ASM_IDLE;
                d.cnt   = '0;
                d.bitn  = '0;
            end else begin
                case (q.state)
                    ASM_IDLE: begin
                        if (q.prev && !rx_s) begin
                            d.state = ASM_START;
                            d.cnt   = '0;
                        end
                    end
                    ASM_START: begin
                        if (q.cnt == CNT_W'(HALF - 1)) begin
                            d.cnt  = '0;
                            d.bitn = '0;
                            d.state = rx_s ? ASM_IDLE : ASM_DATA;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    ASM_DATA: begin
                        if (q.cnt == CNT_W'(OSR - 1)) begin
                            d.cnt   = '0;
                            d.shreg = {rx_s, q.shreg[DATA_W-1:1]};
                            if (q.bitn == BIT_W'(DATA_W - 1)) begin
                                d.state = ASM_STOP;
                            end else begin
                                d.bitn = q.bitn + 1'b1;
                            end
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (q.cnt == CNT_W'(OSR - 1)) begin
                            done    = 1'b1;
                            d.cnt   = '0;
                            d.state = ASM_IDLE;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ASM_IDLE;
            q.prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/srx_ring.sv
module srx_ring #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3,
    parameter int STAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STAT_W-1:0] wr_stat,
    input  logic              rd_stb,
    input  logic              realign,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] rd_stat,
    output logic              nonempty,
    output logic              dropped
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DEPTH-1:0][STAT_W-1:0] stat;
        logic [PW-1:0]                wr;
        logic [PW-1:0]                rd;
        logic [CW-1:0]                fill;
    } ring_t;

    ring_t q, d;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic full, do_wr, do_dec;

    always_comb begin
        d       = q;
        full    = (q.fill == CW'(DEPTH));
        do_wr   = wr_stb && !full;
        do_dec  = rd_stb && (q.fill != '0);
        dropped = 1'b0;
        if (realign) begin
            d.rd          = q.wr;
            d.fill        = '0;
            d.stat[q.wr]  = '0;
        end else begin
            dropped = wr_stb && full;
            if (do_wr) begin
                d.mem[q.wr]  = wr_data;
                d.stat[q.wr] = wr_stat;
                d.wr         = step(q.wr);
            end
            if (rd_stb) begin
                d.rd = step(q.rd);
            end
            if (do_wr && !do_dec) begin
                d.fill = q.fill + 1'b1;
            end else if (!do_wr && do_dec) begin
                d.fill = q.fill - 1'b1;
            end
        end
    end

    assign rd_data  = q.mem[q.rd];
    assign rd_stat  = q.stat[q.rd];
    assign nonempty = (q.fill != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/serial_rx_ctl.sv
module serial_rx_ctl
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              cmd_en,
    input  logic              cmd_dis,
    input  logic              cmd_rst,
    input  logic              rd_stb,
    output logic              rx_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_frm_err,
    output logic              rd_brk,
    output logic              overrun,
    output logic              rx_on
);
    typedef struct packed {
        logic [1:0] sync;
        logic       on;
        logic       ovr;
    } ctl_t;

    ctl_t q, d;

    logic              asm_en;
    logic              asm_done;
    logic [DATA_W-1:0] asm_data;
    logic              asm_fe;
    logic              accept;
    logic [STAT_W-1:0] new_stat;
    logic [STAT_W-1:0] head_stat;
    logic              ring_drop;

    assign asm_en = q.on && !cmd_dis && !cmd_rst;
    assign accept = asm_done && asm_en;

    always_comb begin
        new_stat           = '0;
        new_stat[STAT_FE]  = asm_fe;
        new_stat[STAT_BRK] = asm_fe && (asm_data == '0);
    end

    srx_assembler #(
        .DATA_W (DATA_W),
        .OSR    (OSR)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .rx_s      (q.sync[1]),
        .en        (asm_en),
        .done      (asm_done),
        .done_data (asm_data),
        .done_fe   (asm_fe)
    );

    srx_ring #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .STAT_W (STAT_W)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (accept),
        .wr_data  (asm_data),
        .wr_stat  (new_stat),
        .rd_stb   (rd_stb),
        .realign  (cmd_rst),
        .rd_data  (rd_data),
        .rd_stat  (head_stat),
        .nonempty (rx_ready),
        .dropped  (ring_drop)
    );

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rx_in};
        if (cmd_rst) begin
            d.on  = 1'b0;
            d.ovr = 1'b0;
        end else begin
            if (cmd_dis) begin
                d.on = 1'b0;
            end else if (cmd_en) begin
                d.on = 1'b1;
            end
            if (ring_drop && asm_en) begin
                d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign rd_frm_err = head_stat[STAT_FE];
    assign rd_brk     = head_stat[STAT_BRK];
    assign overrun    = q.ovr;
    assign rx_on      = q.on;
endmodule

// File: rtl/serial_rx_ctl_chk.sv
module serial_rx_ctl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_en,
    input logic              cmd_dis,
    input logic              cmd_rst,
    input logic              rx_ready,
    input logic              overrun,
    input logic              rx_on,
    input logic [DATA_W-1:0] rd_data
);
    p_rst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (!rx_ready && !overrun && !rx_on));

    p_dis_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_dis && !cmd_rst) |=> !rx_on);

    p_on_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_on) |-> $past(cmd_en && !cmd_dis && !cmd_rst));

    p_no_store_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(rx_on));

    p_ovr_when_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_ready));
endmodule

bind serial_rx_ctl serial_rx_ctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_en   (cmd_en),
    .cmd_dis  (cmd_dis),
    .cmd_rst  (cmd_rst),
    .rx_ready (rx_ready),
    .overrun  (overrun),
    .rx_on    (rx_on),
    .rd_data  (rd_data)
);

// File: tb/tb_serial_rx_ctl.sv
module tb_serial_rx_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int BITLEN     = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic       cmd_en = 1'b0, cmd_dis = 1'b0, cmd_rst = 1'b0, rd_stb = 1'b0;
    logic       rx_ready, rd_frm_err, rd_brk, overrun, rx_on;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rx_ctl dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_rst(cmd_rst), .rd_stb(rd_stb),
        .rx_ready(rx_ready), .rd_data(rd_data), .rd_frm_err(rd_frm_err),
        .rd_brk(rd_brk), .overrun(overrun), .rx_on(rx_on)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic e, input logic ds, input logic r);
        cmd_en = e; cmd_dis = ds; cmd_rst = r;
        wait_clk(1);
        cmd_en = 1'b0; cmd_dis = 1'b0; cmd_rst = 1'b0;
        wait_clk(1);
    endtask

    task automatic rd_pulse();
        rd_stb = 1'b1;
        wait_clk(1);
        rd_stb = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic stop);
        rx_in = 1'b0; wait_clk(BITLEN);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i]; wait_clk(BITLEN);
        end
        rx_in = stop; wait_clk(BITLEN);
        rx_in = 1'b1; wait_clk(BITLEN);
    endtask

    task automatic fresh();
        cmd(1'b0, 1'b0, 1'b1);
        cmd(1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_reset_state();
        check("R9 reset rx_ready", rx_ready, 0);
        check("R9 reset rx_on", rx_on, 0);
        check("R9 reset overrun", overrun, 0);
    endtask

    task automatic t_basic();
        fresh();
        check("R11 enable sets rx_on", rx_on, 1);
        send(8'hA5, 1'b1);
        check("R1 ready after frame", rx_ready, 1);
        check("R1 data", rd_data, 8'hA5);
        check("R3 good stop fe", rd_frm_err, 0);
        rd_pulse();
        check("R4 ready clears after read", rx_ready, 0);
        send(8'h3C, 1'b1);
        check("R1 second data", rd_data, 8'h3C);
        rd_pulse();
    endtask

    task automatic t_glitch();
        fresh();
        rx_in = 1'b0; wait_clk(5);
        rx_in = 1'b1; wait_clk(40);
        check("R2 glitch not stored", rx_ready, 0);
        send(8'h5A, 1'b1);
        check("R2 frame after glitch", rd_data, 8'h5A);
        check("R2 ready after glitch", rx_ready, 1);
        rd_pulse();
    endtask

    task automatic t_status();
        fresh();
        send(8'hC3, 1'b0);
        check("R3 fe on low stop", rd_frm_err, 1);
        check("R3 no brk nonzero", rd_brk, 0);
        rd_pulse();
        send(8'h00, 1'b0);
        check("R3 brk on zero frame", rd_brk, 1);
        check("R3 fe with brk", rd_frm_err, 1);
        rd_pulse();
    endtask

    task automatic t_overrun();
        fresh();
        send(8'h31, 1'b1);
        send(8'h32, 1'b1);
        send(8'h33, 1'b1);
        check("R5 no overrun at three", overrun, 0);
        send(8'h34, 1'b1);
        check("R5 overrun set", overrun, 1);
        check("R4 order 1", rd_data, 8'h31); rd_pulse();
        check("R4 order 2", rd_data, 8'h32); rd_pulse();
        check("R5 order 3 kept", rd_data, 8'h33); rd_pulse();
        check("R4 empty after three", rx_ready, 0);
        check("R10 stale read value", rd_data, 8'h31);
        rd_pulse();
        check("R10 next stale value", rd_data, 8'h32);
        check("R5 overrun sticky", overrun, 1);
        cmd(1'b0, 1'b0, 1'b1);
        check("R5 overrun cleared by reset", overrun, 0);
    endtask

    task automatic t_disable_hold();
        fresh();
        send(8'h77, 1'b1);
        cmd(1'b0, 1'b1, 1'b0);
        check("R6 rx_on low after disable", rx_on, 0);
        send(8'h88, 1'b1);
        check("R7 stored data readable", rd_data, 8'h77);
        rd_pulse();
        check("R7 frame ignored while off", rx_ready, 0);
    endtask

    task automatic t_midframe();
        fresh();
        fork
            send(8'hF0, 1'b1);
            begin
                wait_clk(80);
                cmd_dis = 1'b1; wait_clk(1); cmd_dis = 1'b0;
            end
        join
        check("R6 partial discarded", rx_ready, 0);
        cmd(1'b1, 1'b0, 1'b0);
        send(8'h96, 1'b1);
        check("R8 next frame data", rd_data, 8'h96);
        rd_pulse();
        check("R8 only one char", rx_ready, 0);
    endtask

    task automatic t_rst_realign();
        fresh();
        send(8'h00, 1'b0);
        send(8'h11, 1'b1);
        send(8'h22, 1'b1);
        cmd(1'b0, 1'b0, 1'b1);
        check("R9 ready cleared", rx_ready, 0);
        check("R9 head data kept", rd_data, 8'h00);
        check("R9 head fe cleared", rd_frm_err, 0);
        check("R9 head brk cleared", rd_brk, 0);
        send(8'h44, 1'b1);
        check("R9 off until enabled", rx_ready, 0);
        rd_pulse();
        check("R10 read past empty", rd_data, 8'h11);
        rd_pulse();
        check("R10 read past empty 2", rd_data, 8'h22);
    endtask

    task automatic t_priority();
        cmd(1'b0, 1'b0, 1'b1);
        cmd(1'b1, 1'b1, 1'b0);
        check("R11 disable beats enable", rx_on, 0);
        cmd(1'b1, 1'b0, 1'b1);
        check("R11 reset beats enable", rx_on, 0);
        cmd(1'b1, 1'b0, 1'b0);
        check("R11 enable alone", rx_on, 1);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset_state();
        t_basic();
        t_glitch();
        t_status();
        t_overrun();
        t_disable_hold();
        t_midframe();
        t_rst_realign();
        t_priority();
        report();
    end
endmodule